// File: doc/BRIEF.md
# Serial Adapter Register File and Interrupt Logic

This block is the processor side of an asynchronous serial adapter. It sits on an 8-bit bus with two chip selects, a two-bit register address and a read/write line. It keeps the command and control registers and builds the status byte. It also emits one-cycle strobes that tell the transmitter a byte was written and tell the receiver its byte was read. The shift registers, baud generator and pads sit elsewhere. They report back through a transmit-taken pulse and a receive-done pulse with error flags.

The status byte mixes three kinds of bit. Some are sticky flags that a bus access clears. The error flags survive until a clean byte arrives after the host has emptied the receive register. The modem lines are shown live. An active-low interrupt request follows the pending bit. The receive, transmit-empty and modem-change sources can each be enabled from the command register. A programmed reset is a write to the status address. It wipes only the lower command bits and the overrun flag.

Top module: `sacia_regs`

## Requirements
- R1: A bus access takes effect only when `bus_en`=1, `cs_hi`=1 and `cs_lo_n`=0. Any other access produces no strobe and changes no register, and `rdata` reads 0.
- R2: The register address selects as follows on a read (`rd_wr`=1): code 0 returns `rx_data`, 1 the status byte, 2 the command register and 3 the control register. Writes (`rd_wr`=0) to codes 2 and 3 load those registers. Status bits from 7 down to 0 are: pending, DCD pin level, DSR pin level, transmit empty, receive full, overrun, framing error, parity error.
- R3: A synchronous `rst` clears the command and control registers. It sets the status byte to pending 0, transmit empty 1 and receive full 0, with all three error bits 0.
- R4: A write to code 1 ignores its data. It clears command bits 4:0 and the overrun bit. It leaves command bits 7:5, the control register and all other status bits unchanged.
- R5: A write to code 0 raises `tx_wr_stb` for that cycle and clears transmit empty. `tx_taken` sets transmit empty again.
- R6: A reception (`rx_done`) sets receive full. It is ignored while command bit 0 is 0. A read of code 0 raises `rx_rd_stb` for that cycle and clears receive full.
- R7: A reception while receive full is set and not being read in the same cycle is an overrun. It sets the overrun bit, leaves receive full set and raises no interrupt.
- R8: An accepted reception with `rx_perr` or `rx_ferr` set sets the matching error bits. Those bits and the overrun bit persist until a later accepted reception with neither flag set clears all three. None of them raises an interrupt.
- R9: Status bits 6 and 5 show the DCD and DSR pin levels after a synchronizer. With command bit 0 at 1, a level change on either line sets pending.
- R10: With command bit 0 at 1 and command bit 1 at 0, an accepted reception sets pending. With command bit 1 at 1 it does not.
- R11: With command bit 0 at 1 and command bits 3:2 equal to 01, pending is set while transmit empty is 1, and a status read does not clear it. Other values of bits 3:2 give no transmit interrupt.
- R12: `irq_n` is low exactly while pending is 1. A status read clears pending unless the transmit interrupt is enabled. Command bit 0 at 0 clears pending and holds it at 0.
- R13: `dtr_n` is the inverse of command bit 0. `rts_n` is high only when command bits 3:2 are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| bus_en | input | 1 | Bus cycle qualifier |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| tx_wr_stb | output | 1 | Transmit byte written this cycle |
| rx_rd_stb | output | 1 | Receive byte read this cycle |
| tx_taken | input | 1 | Transmitter has taken the byte |
| rx_done | input | 1 | Receiver has completed a byte |
| rx_data | input | 8 | Received byte from the receiver |
| rx_perr | input | 1 | Parity error on the completed byte |
| rx_ferr | input | 1 | Framing error on the completed byte |
| dsr_n | input | 1 | Data set ready pin, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, asynchronous |
| cmd_q | output | 8 | Command register contents |
| ctl_q | output | 8 | Control register contents |
| irq_n | output | 1 | Interrupt request, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
Most internal state shows up at the ports one cycle after the edge that changed it. A wrong pending bit appears at once on `irq_n` and on status bit 7. A wrong receive-full, transmit-empty or error flag appears on the next status read. A programmed reset that clears too much or too little shows on the read-back of the command, control and status registers straight after it. Modem-line faults need a few cycles to appear, because of the synchronizer. The bench therefore waits out that depth before it judges the status levels or the interrupt they cause.

// File: rtl/sacia_pkg.sv
package sacia_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_CTL  = 2'd3
    } regsel_e;

    typedef struct packed {
        logic irq;
        logic dcd;
        logic dsr;
        logic tx_empty;
        logic rx_full;
        logic ovr;
        logic fe;
        logic pe;
    } status_t;

    typedef struct packed {
        logic [2:0] parity;
        logic       echo;
        logic [1:0] txc;
        logic       rx_irq_off;
        logic       ready;
    } cmd_t;

    function automatic logic tx_irq_on(cmd_t c);
        return c.txc == 2'b01;
    endfunction

    function automatic logic rts_active(cmd_t c);
        return c.txc != 2'b00;
    endfunction

endpackage

// File: rtl/sacia_bus_dec.sv
module sacia_bus_dec
    import sacia_pkg::*;
(
    input  logic    bus_en,
    input  logic    cs_hi,
    input  logic    cs_lo_n,
    input  logic    rd_wr,
    input  regsel_e sel,
    output logic    tdr_wr,
    output logic    prog_rst,
    output logic    cmd_wr,
    output logic    ctl_wr,
    output logic    rdr_rd,
    output logic    sts_rd,
    output logic    rd_act
);
    logic hit;
    logic [3:0] wr_1h;

    assign hit    = bus_en & cs_hi & ~cs_lo_n;
    assign rd_act = hit & rd_wr;

    always_comb begin
        wr_1h = '0;
        if (hit && !rd_wr) wr_1h[sel] = 1'b1;
    end

    assign tdr_wr   = wr_1h[SEL_DATA];
    assign prog_rst = wr_1h[SEL_STAT];
    assign cmd_wr   = wr_1h[SEL_CMD];
    assign ctl_wr   = wr_1h[SEL_CTL];
    assign rdr_rd   = rd_act && (sel == SEL_DATA);
    assign sts_rd   = rd_act && (sel == SEL_STAT);
endmodule

// File: rtl/sacia_modem_sync.sv
module sacia_modem_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pin,
    output logic [LINES-1:0] lvl,
    output logic             chg
);
    logic [LINES-1:0] moved;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], pin[g]};
                prev  <= chain[STAGES-1];
            end
        end
        assign lvl[g]   = chain[STAGES-1];
        assign moved[g] = chain[STAGES-1] ^ prev;
    end

    assign chg = |moved;
endmodule

// File: rtl/sacia_status.sv
module sacia_status
    import sacia_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    prog_rst,
    input  logic    tdr_wr,
    input  logic    rdr_rd,
    input  logic    sts_rd,
    input  logic    tx_taken,
    input  logic    rx_done,
    input  logic    rx_perr,
    input  logic    rx_ferr,
    input  logic    rx_en,
    input  logic    rx_ie,
    input  logic    tx_ie,
    input  logic    modem_chg,
    input  logic    dcd_lvl,
    input  logic    dsr_lvl,
    output status_t stat
);
    logic irq_q, txe_q, rxf_q, ovr_q, fe_q, pe_q;
    logic accept, overrun, clean, irq_set;

    assign accept  = rx_done & rx_en & (~rxf_q | rdr_rd);
    assign overrun = rx_done & rx_en & rxf_q & ~rdr_rd;
    assign clean   = ~(rx_perr | rx_ferr);
    assign irq_set = rx_en & ((tx_ie & txe_q) | (rx_ie & accept) | modem_chg);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            txe_q <= 1'b1;
            rxf_q <= 1'b0;
            ovr_q <= 1'b0;
            fe_q  <= 1'b0;
            pe_q  <= 1'b0;
        end else begin
            if (tdr_wr)        txe_q <= 1'b0;
            else if (tx_taken) txe_q <= 1'b1;

            if (accept)      rxf_q <= 1'b1;
            else if (rdr_rd) rxf_q <= 1'b0;

            if (accept) begin
                if (clean) begin
                    pe_q <= 1'b0;
                    fe_q <= 1'b0;
                end else begin
                    pe_q <= pe_q | rx_perr;
                    fe_q <= fe_q | rx_ferr;
                end
            end

            if (prog_rst)            ovr_q <= 1'b0;
            else if (accept && clean) ovr_q <= 1'b0;
            else if (overrun)        ovr_q <= 1'b1;

            if (!rx_en)                irq_q <= 1'b0;
            else if (irq_set)          irq_q <= 1'b1;
            else if (sts_rd && !tx_ie) irq_q <= 1'b0;
        end
    end

    always_comb begin
        stat.irq      = irq_q;
        stat.dcd      = dcd_lvl;
        stat.dsr      = dsr_lvl;
        stat.tx_empty = txe_q;
        stat.rx_full  = rxf_q;
        stat.ovr      = ovr_q;
        stat.fe       = fe_q;
        stat.pe       = pe_q;
    end
endmodule

// File: rtl/sacia_regs.sv
module sacia_regs
    import sacia_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              rd_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_wr_stb,
    output logic              rx_rd_stb,
    input  logic              tx_taken,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              dsr_n,
    input  logic              dcd_n,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] ctl_q,
    output logic              irq_n,
    output logic              dtr_n,
    output logic              rts_n
);
    localparam int CLR_BITS = 5;

    regsel_e sel;
    logic    tdr_wr, prog_rst, cmd_wr, ctl_wr, rdr_rd, sts_rd, rd_act;
    cmd_t    cmd;
    status_t stat;
    logic [1:0] modem_lvl;
    logic    modem_chg;

    assign sel = regsel_e'(reg_sel);
    assign cmd = cmd_t'(cmd_q);

    sacia_bus_dec u_dec (
        .bus_en  (bus_en),
        .cs_hi   (cs_hi),
        .cs_lo_n (cs_lo_n),
        .rd_wr   (rd_wr),
        .sel     (sel),
        .tdr_wr  (tdr_wr),
        .prog_rst(prog_rst),
        .cmd_wr  (cmd_wr),
        .ctl_wr  (ctl_wr),
        .rdr_rd  (rdr_rd),
        .sts_rd  (sts_rd),
        .rd_act  (rd_act)
    );

    sacia_modem_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .pin({dcd_n, dsr_n}),
        .lvl(modem_lvl),
        .chg(modem_chg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            ctl_q <= '0;
        end else begin
            if (prog_rst)    cmd_q[CLR_BITS-1:0] <= '0;
            else if (cmd_wr) cmd_q <= wdata;
            if (ctl_wr)      ctl_q <= wdata;
        end
    end

    sacia_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .prog_rst (prog_rst),
        .tdr_wr   (tdr_wr),
        .rdr_rd   (rdr_rd),
        .sts_rd   (sts_rd),
        .tx_taken (tx_taken),
        .rx_done  (rx_done),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr),
        .rx_en    (cmd.ready),
        .rx_ie    (~cmd.rx_irq_off),
        .tx_ie    (tx_irq_on(cmd)),
        .modem_chg(modem_chg),
        .dcd_lvl  (modem_lvl[1]),
        .dsr_lvl  (modem_lvl[0]),
        .stat     (stat)
    );

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (sel)
                SEL_DATA: rdata = rx_data;
                SEL_STAT: rdata = stat;
                SEL_CMD:  rdata = cmd_q;
                SEL_CTL:  rdata = ctl_q;
            endcase
        end
    end

    assign tx_wr_stb = tdr_wr;
    assign rx_rd_stb = rdr_rd;
    assign irq_n     = ~stat.irq;
    assign dtr_n     = ~cmd.ready;
    assign rts_n     = ~rts_active(cmd);
endmodule

// File: rtl/sacia_regs_chk.sv
module sacia_regs_chk
    import sacia_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] cmd_q,
    input logic [7:0] ctl_q,
    input status_t    stat,
    input logic       irq_n,
    input logic       tdr_wr,
    input logic       rdr_rd,
    input logic       prog_rst,
    input logic       cmd_wr,
    input logic       ctl_wr,
    input logic       rx_done
);
    // R12
    no_irq_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_q[0] |=> irq_n);

    // R5
    tdr_write_empties_chk: assert property (@(posedge clk) disable iff (rst)
        tdr_wr |=> !stat.tx_empty);

    // R6
    rdr_read_drains_chk: assert property (@(posedge clk) disable iff (rst)
        (rdr_rd && !rx_done) |=> !stat.rx_full);

    // R4
    prog_reset_scope_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_rst && !ctl_wr) |=> (cmd_q[4:0] == 5'd0) && !stat.ovr && $stable(ctl_q) && $stable(cmd_q[7:5]));

    // R7
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && cmd_q[0] && stat.rx_full && !rdr_rd && !prog_rst && !cmd_wr) |=> stat.ovr && stat.rx_full);
endmodule

bind sacia_regs sacia_regs_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cmd_q   (cmd_q),
    .ctl_q   (ctl_q),
    .stat    (stat),
    .irq_n   (irq_n),
    .tdr_wr  (tdr_wr),
    .rdr_rd  (rdr_rd),
    .prog_rst(prog_rst),
    .cmd_wr  (cmd_wr),
    .ctl_wr  (ctl_wr),
    .rx_done (rx_done)
);

// File: tb/tb_sacia_regs.sv
`timescale 1ns/1ps
module tb_sacia_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0, cs_hi = 1'b0, cs_lo_n = 1'b1, rd_wr = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wdata = 8'h00, rdata, rx_data = 8'hC3, cmd_q, ctl_q;
    logic       tx_wr_stb, rx_rd_stb, irq_n, dtr_n, rts_n;
    logic       tx_taken = 1'b0, rx_done = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
    logic       dsr_n = 1'b1, dcd_n = 1'b0;
    logic       probe = 1'b0;
    int         n_chk = 0, n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    sacia_regs dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .rd_wr(rd_wr), .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
        .tx_wr_stb(tx_wr_stb), .rx_rd_stb(rx_rd_stb), .tx_taken(tx_taken),
        .rx_done(rx_done), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .dsr_n(dsr_n), .dcd_n(dcd_n), .cmd_q(cmd_q), .ctl_q(ctl_q),
        .irq_n(irq_n), .dtr_n(dtr_n), .rts_n(rts_n)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (probe) begin
            item_t it;
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL scoreboard: got %02h expected nothing", rdata);
            end else begin
                it = sb_q.pop_front();
                chk(it.req, rdata, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        bus_en = 1'b0; cs_hi = 1'b0; cs_lo_n = 1'b1; rd_wr = 1'b1;
        rx_done = 1'b0; tx_taken = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
        probe = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic rd_cs(logic en, logic ch, logic cl, logic [1:0] s, logic [7:0] exp, string req);
        cyc();
        bus_en = en; cs_hi = ch; cs_lo_n = cl; rd_wr = 1'b1; reg_sel = s;
        sb_q.push_back('{exp, req});
        probe = 1'b1;
        #0.5;
        if (s == 2'd0) chk({req, " rx_rd_stb"}, {7'd0, rx_rd_stb}, {7'd0, en & ch & ~cl});
    endtask

    task automatic rd(logic [1:0] s, logic [7:0] exp, string req);
        rd_cs(1'b1, 1'b1, 1'b0, s, exp, req);
    endtask

    task automatic wr_cs(logic en, logic ch, logic cl, logic [1:0] s, logic [7:0] d, string req);
        cyc();
        bus_en = en; cs_hi = ch; cs_lo_n = cl; rd_wr = 1'b0; reg_sel = s; wdata = d;
        #0.5;
        if (s == 2'd0) chk({req, " tx_wr_stb"}, {7'd0, tx_wr_stb}, {7'd0, en & ch & ~cl});
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d, string req);
        wr_cs(1'b1, 1'b1, 1'b0, s, d, req);
    endtask

    task automatic rx_evt(logic pe, logic fe);
        cyc();
        rx_done = 1'b1; rx_perr = pe; rx_ferr = fe;
    endtask

    task automatic tx_evt();
        cyc();
        tx_taken = 1'b1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        idle(4);
        // R3 reset values, dcd_n=0 dsr_n=1
        rd(2'd1, 8'h30, "R3 status");
        rd(2'd2, 8'h00, "R3 command");
        rd(2'd3, 8'h00, "R3 control");
        idle(1);
        chk("R13 dtr_n reset", {7'd0, dtr_n}, 8'd1);
        chk("R13 rts_n reset", {7'd0, rts_n}, 8'd1);
        chk("R12 irq_n reset", {7'd0, irq_n}, 8'd1);

        // R1 deselected accesses
        wr_cs(1'b1, 1'b1, 1'b1, 2'd3, 8'h55, "R1");
        wr_cs(1'b0, 1'b1, 1'b0, 2'd0, 8'h55, "R1");
        rd(2'd3, 8'h00, "R1 control untouched");
        rd(2'd1, 8'h30, "R1 tx empty untouched");
        rd_cs(1'b1, 1'b0, 1'b0, 2'd3, 8'h00, "R1 read deselected");

        // R2 register access
        wr(2'd3, 8'h9A, "R2");
        rd(2'd3, 8'h9A, "R2 control");
        wr(2'd2, 8'hE1, "R2");
        rd(2'd2, 8'hE1, "R2 command");
        idle(1);
        chk("R13 dtr_n on", {7'd0, dtr_n}, 8'd0);
        chk("R13 rts_n 00", {7'd0, rts_n}, 8'd1);

        // R5 transmit empty
        wr(2'd0, 8'h41, "R5");
        rd(2'd1, 8'h20, "R5 empty cleared");
        tx_evt();
        rd(2'd1, 8'h30, "R5 empty set");
        idle(1);
        chk("R11 no tx irq with 00", {7'd0, irq_n}, 8'd1);

        // R6 R10 reception
        rx_evt(1'b0, 1'b0);
        idle(1);
        chk("R10 rx irq", {7'd0, irq_n}, 8'd0);
        rd(2'd1, 8'hB8, "R6 R10 status");
        idle(1);
        chk("R12 read clears", {7'd0, irq_n}, 8'd1);
        rd(2'd0, 8'hC3, "R2 R6 rx data");
        rd(2'd1, 8'h30, "R6 full cleared");

        // R7 R8 errors
        rx_evt(1'b1, 1'b0);
        rd(2'd1, 8'hB9, "R8 parity");
        rx_evt(1'b0, 1'b0);
        idle(1);
        chk("R7 no irq on overrun", {7'd0, irq_n}, 8'd1);
        rd(2'd1, 8'h3D, "R7 overrun");
        rd(2'd0, 8'hC3, "R6");
        rd(2'd1, 8'h35, "R8 errors persist");
        rx_evt(1'b0, 1'b1);
        rd(2'd1, 8'hBF, "R8 framing");
        rd(2'd0, 8'hC3, "R6");
        rx_evt(1'b0, 1'b0);
        rd(2'd1, 8'hB8, "R8 clean clears");
        rd(2'd0, 8'hC3, "R6");
        rd(2'd1, 8'h30, "R6");

        // R10 rx irq disabled
        wr(2'd2, 8'hE3, "R10");
        rx_evt(1'b0, 1'b0);
        idle(1);
        chk("R10 masked", {7'd0, irq_n}, 8'd1);
        rd(2'd1, 8'h38, "R10 masked status");
        rd(2'd0, 8'hC3, "R6");

        // R9 modem lines
        cyc(); dsr_n = 1'b0;
        idle(4);
        chk("R9 dsr change irq", {7'd0, irq_n}, 8'd0);
        rd(2'd1, 8'h90, "R9 dsr level");
        cyc(); dcd_n = 1'b1;
        idle(4);
        rd(2'd1, 8'hD0, "R9 dcd level");
        idle(1);
        chk("R12 cleared", {7'd0, irq_n}, 8'd1);

        // R11 transmit irq
        wr(2'd2, 8'hE5, "R11");
        idle(2);
        chk("R11 tx irq", {7'd0, irq_n}, 8'd0);
        chk("R13 rts_n 01", {7'd0, rts_n}, 8'd0);
        rd(2'd1, 8'hD0, "R11 status");
        idle(1);
        chk("R11 read keeps", {7'd0, irq_n}, 8'd0);
        wr(2'd0, 8'h11, "R5");
        tx_evt();

        // R12 R6 command bit 0 off
        wr(2'd2, 8'hE4, "R12");
        idle(2);
        chk("R12 off clears", {7'd0, irq_n}, 8'd1);
        chk("R13 dtr_n off", {7'd0, dtr_n}, 8'd1);
        rx_evt(1'b0, 1'b0);
        rd(2'd1, 8'h50, "R6 receiver disabled");

        // R4 programmed reset
        wr(2'd2, 8'hE3, "R4");
        rx_evt(1'b0, 1'b0);
        rx_evt(1'b0, 1'b0);
        rd(2'd1, 8'h5C, "R7 before reset");
        wr(2'd1, 8'hAA, "R4");
        rd(2'd2, 8'hE0, "R4 command");
        rd(2'd3, 8'h9A, "R4 control");
        rd(2'd1, 8'h58, "R4 status");
        idle(1);
        chk("R4 R13 dtr_n", {7'd0, dtr_n}, 8'd1);
        idle(2);
        report();
    end
endmodule